// File: doc/BRIEF.md
# Transmit-Low Watchdog with Qualified Re-Arm

This block guards a CAN transmit path against a controller that holds its transmit line low for too long. While the transceiver is in its normal (transmitting) mode, the block counts the clock cycles in which the synchronized transmit input is low. Once that count reaches a set limit, it latches a lockout. While the lockout is set, the permission to drive a dominant level is withdrawn, so the bus goes back to recessive.

The lockout and the low-time count are cleared in only two ways. The transmit input can stay high for a qualifying number of consecutive cycles, or the normal mode can be left. A high pulse shorter than the qualifying run does not clear anything. The low cycles on either side of such a pulse add up toward the limit. Both durations are parameters counted in clock cycles.

Top module: `txd_dom_guard`

## Requirements
- R1: During and directly after reset, `lockout` is 0, and `drive_en` is 0 whenever `normal_en` is 0.
- R2: In normal mode (`normal_en`=1) with no lockout, `drive_en` is 1 exactly when `txd_sync` is 0 (0 means dominant is requested). It follows the input in the same cycle.
- R3: `lockout` becomes 1 at the clock edge that samples the TIMEOUT_CYC-th low cycle counted since the last clear, and not earlier. From that cycle on, `drive_en` is 0.
- R4: While `lockout` is 1, `drive_en` stays 0 even when `txd_sync` goes low again.
- R5: At the clock edge that samples the REARM_CYC-th consecutive high cycle in normal mode, `lockout` and the low-time count are both cleared.
- R6: A high run shorter than REARM_CYC cycles neither clears `lockout` nor resets the low-time count. Low cycles before and after such a run accumulate toward TIMEOUT_CYC.
- R7: Any clock edge that samples `normal_en`=0 clears `lockout`, the low-time count and the high-run count. `drive_en` is 0 while `normal_en` is 0.
- R8: Low cycles sampled outside normal mode never count toward the limit, so `lockout` never rises while `normal_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| normal_en | input | 1 | 1 while the transceiver is in its transmitting mode |
| txd_sync | input | 1 | Synchronized transmit data, 0 = dominant request |
| drive_en | output | 1 | 1 permits the driver to put a dominant level on the bus |
| lockout | output | 1 | 1 while the timeout lockout is latched |

## Verification
The embedded properties check, on every cycle, four things: the lockout only rises after the low count has reached the edge of the limit with the input low; a qualifying high run always leaves the lockout and the count at zero; a sub-qualifying high cycle leaves the low count unchanged; and any cycle outside normal mode leaves the lockout clear. The bench's scenarios show the behaviour that builds up over time against a cycle-accurate model of its own. This covers the exact cycle of the lockout after a long low run, low time accumulated across short high glitches, the lockout holding against a fresh low request, and release by a qualifying high run or by leaving normal mode.

// File: rtl/txd_guard_pkg.sv
package txd_guard_pkg;

  // counter width able to hold 0..limit
  function automatic int unsigned run_cnt_w(input int unsigned limit);
    return (limit < 2) ? 1 : $clog2(limit + 1);
  endfunction

  // true when the sample being taken is the limit-th of a run
  function automatic bit run_completes(input int unsigned cnt_now,
                                       input int unsigned limit);
    return (cnt_now + 1) == limit;
  endfunction

endpackage

// File: rtl/txd_run_counter.sv
module txd_run_counter
  import txd_guard_pkg::*;
#(
  parameter int unsigned LIMIT = 8,
  localparam int unsigned CW   = run_cnt_w(LIMIT)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  output logic [CW-1:0] cnt,
  output logic          hit
);

  logic [CW-1:0] cnt_q;
  logic          at_limit;

  assign at_limit = (cnt_q == CW'(LIMIT));
  assign hit      = inc && !clr && run_completes(int'(cnt_q), LIMIT);
  assign cnt      = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr)              cnt_q <= '0;
    else if (inc && !at_limit) cnt_q <= cnt_q + 1'b1;
  end

  // R6/R5 support: the count never passes its ceiling
  p_cnt_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/txd_lock_flag.sv
module txd_lock_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic mode_on,
  input  logic set_ev,
  input  logic clr_ev,
  output logic locked
);

  logic lock_q;
  assign locked = lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        lock_q <= 1'b0;
    else if (!mode_on) lock_q <= 1'b0;
    else if (clr_ev)   lock_q <= 1'b0;
    else if (set_ev)   lock_q <= 1'b1;
  end

  p_mode_exit_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_on |=> !lock_q);

endmodule

// File: rtl/txd_dom_guard.sv
module txd_dom_guard
  import txd_guard_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 40,
  parameter int unsigned REARM_CYC   = 8,
  localparam int unsigned LOW_W      = run_cnt_w(TIMEOUT_CYC),
  localparam int unsigned HIGH_W     = run_cnt_w(REARM_CYC)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic normal_en,
  input  logic txd_sync,
  output logic drive_en,
  output logic lockout
);

  // named internal events
  logic              low_sample;
  logic              high_sample;
  logic              rearm_hit;
  logic              timeout_hit;
  logic              low_clr;
  logic              high_clr;
  logic [LOW_W-1:0]  low_cnt;
  logic [HIGH_W-1:0] high_cnt;
  logic              lock_state;

  assign low_sample  = normal_en && !txd_sync;
  assign high_sample = normal_en &&  txd_sync;
  assign low_clr     = !normal_en || rearm_hit;
  assign high_clr    = !normal_en || !txd_sync;

  txd_run_counter #(.LIMIT(TIMEOUT_CYC)) u_low_run (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (low_clr),
    .inc   (low_sample),
    .cnt   (low_cnt),
    .hit   (timeout_hit)
  );

  txd_run_counter #(.LIMIT(REARM_CYC)) u_high_run (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (high_clr),
    .inc   (high_sample),
    .cnt   (high_cnt),
    .hit   (rearm_hit)
  );

  txd_lock_flag u_lock (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_on (normal_en),
    .set_ev  (timeout_hit),
    .clr_ev  (rearm_hit),
    .locked  (lock_state)
  );

  assign lockout  = lock_state;
  assign drive_en = low_sample && !lock_state;

  // R3: lockout rises only after a low sample that completed the limit
  p_lock_after_limit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_state) |-> ($past(low_cnt) == LOW_W'(TIMEOUT_CYC - 1)) && $past(low_sample));

  // R5: a qualified high run leaves lockout and low count at zero
  p_rearm_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_hit |=> !lock_state && (low_cnt == '0));

  // R6: a high sample that does not qualify keeps the low count
  p_short_high_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    high_sample && !rearm_hit |=> $stable(low_cnt));

  // R8: no low accumulation outside normal mode
  p_idle_no_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !normal_en |=> !lock_state && (low_cnt == '0));

  // R4: a latched lockout survives a new low request
  p_lock_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state && low_sample |=> lock_state);

endmodule

// File: tb/tb_txd_dom_guard.sv
module tb_txd_dom_guard;

  localparam int TO = 20;
  localparam int RA = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic normal_en = 1'b0;
  logic txd_sync = 1'b1;
  logic drive_en, lockout;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 0;
  string cur_req = "R1";

  // behavioural model state
  int m_low = 0;
  int m_high = 0;
  bit m_lock = 0;

  always #10 clk = ~clk;

  txd_dom_guard #(.TIMEOUT_CYC(TO), .REARM_CYC(RA)) dut (
    .clk(clk), .rst_n(rst_n), .normal_en(normal_en), .txd_sync(txd_sync),
    .drive_en(drive_en), .lockout(lockout)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b at cycle %0d", req, act, exp, cycles);
    end
  endtask

  // reference model: advances on each rising edge
  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n || !normal_en) begin
      m_low <= 0; m_high <= 0; m_lock <= 0;
    end else if (txd_sync) begin
      if (m_high < RA) m_high <= m_high + 1;
      if (m_high + 1 == RA) begin
        m_low <= 0; m_lock <= 0;
      end
    end else begin
      m_high <= 0;
      if (m_low < TO) m_low <= m_low + 1;
      if (m_low + 1 == TO) m_lock <= 1;
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk({cur_req, " lockout"}, lockout, m_lock);
      chk({cur_req, " drive_en"}, drive_en, normal_en && !txd_sync && !m_lock);
    end
  end

  task automatic drive(input logic n, input logic t, input int cyc);
    for (int i = 0; i < cyc; i++) begin
      @(negedge clk); #3;
      normal_en = n; txd_sync = t;
    end
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 20000 && !done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      finish_run();
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1 reset lockout", lockout, 1'b0);
    chk("R1 reset drive", drive_en, 1'b0);
    #3 rst_n = 1'b1;
    drive(1'b0, 1'b0, 3);
    chk("R1 idle drive", drive_en, 1'b0);

    // R2: normal traffic with short low runs
    cur_req = "R2";
    drive(1'b1, 1'b1, RA);
    for (int k = 0; k < 6; k++) begin
      drive(1'b1, 1'b0, 3 + k);
      drive(1'b1, 1'b1, RA);
    end
    @(negedge clk); #1;
    chk("R2 no lock after short runs", lockout, 1'b0);
    drive(1'b1, 1'b0, 1);
    @(negedge clk); #1;
    chk("R2 low gives drive", drive_en, 1'b1);

    // R3: long low triggers lockout exactly at the limit
    cur_req = "R3";
    drive(1'b1, 1'b1, RA);
    drive(1'b1, 1'b0, TO - 1);
    @(negedge clk); #1;
    chk("R3 before limit", lockout, 1'b0);
    drive(1'b1, 1'b0, 1);
    @(negedge clk); #1;
    chk("R3 at limit", lockout, 1'b1);
    chk("R3 drive off", drive_en, 1'b0);

    // R4: lockout holds against short highs and new low
    cur_req = "R4";
    drive(1'b1, 1'b1, RA - 1);
    drive(1'b1, 1'b0, 4);
    @(negedge clk); #1;
    chk("R4 still blocked", drive_en, 1'b0);

    // R5: qualified high run re-arms
    cur_req = "R5";
    drive(1'b1, 1'b1, RA);
    @(negedge clk); #1;
    chk("R5 cleared", lockout, 1'b0);
    drive(1'b1, 1'b0, 1);
    @(negedge clk); #1;
    chk("R5 drive again", drive_en, 1'b1);

    // R6: low time accumulates across a short high pulse
    cur_req = "R6";
    drive(1'b1, 1'b1, RA);
    drive(1'b1, 1'b0, 15);
    drive(1'b1, 1'b1, RA - 3);
    drive(1'b1, 1'b0, TO - 15 - 1);
    @(negedge clk); #1;
    chk("R6 one short", lockout, 1'b0);
    drive(1'b1, 1'b0, 1);
    @(negedge clk); #1;
    chk("R6 accumulated lock", lockout, 1'b1);

    // R7: leaving normal mode clears everything
    cur_req = "R7";
    drive(1'b0, 1'b0, 1);
    @(negedge clk); #1;
    chk("R7 cleared on exit", lockout, 1'b0);
    chk("R7 no drive out of mode", drive_en, 1'b0);
    drive(1'b1, 1'b0, 1);
    @(negedge clk); #1;
    chk("R7 fresh drive", drive_en, 1'b1);

    // R8: low samples outside normal mode do not count
    cur_req = "R8";
    drive(1'b0, 1'b0, TO + 10);
    @(negedge clk); #1;
    chk("R8 no lock idle", lockout, 1'b0);
    drive(1'b1, 1'b0, TO - 1);
    @(negedge clk); #1;
    chk("R8 fresh count", lockout, 1'b0);
    drive(1'b1, 1'b1, RA);
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule